// File: doc/BRIEF.md
# Multi-Slot Keyed Reload Arbiter

This block sits in front of a watchdog down-counter and decides when the counter may be reloaded. It has up to eight request slots, and each slot belongs to a separate software task. A task marks its slot by writing a fixed 32-bit key to that slot's address. A mask selects which slots take part. The block issues a single-cycle reload grant only when every slot selected by the mask has been marked. In the same clock edge it clears all marks, so the next reload needs a fresh key write from every participating task.

Writes reach the block on a valid/ready write channel. The block never applies back-pressure: `wr_ready` is held high and a write transfers in every cycle where `wr_valid` is high. A level input `wd_running` says whether the watchdog is counting. A pulse input `wd_start` marks the moment it starts. The mask and a pending-status word come out as plain outputs.

Top module: `reload_arbiter`

## Requirements
- R1: Slot i sits at write address 0x600 + 4*i (12-bit address). A key write to an enabled slot while `wd_running` is 1 marks that slot, and the slot's status bit drops to 0 after the edge.
- R2: Only the exact value 0x6E524635 counts as the key. A write of any other value to a slot address is ignored and does not clear a mark made earlier.
- R3: A key write to a slot that is disabled in the mask, or any key write while `wd_running` is 0, leaves the marks unchanged.
- R4: `reload_grant` is high for exactly one cycle, in the cycle after the edge that completes the set of enabled marks. It is produced only while `wd_running` is 1.
- R5: `pend_status[i]` reads 1 when slot i is enabled and not yet marked, and 0 otherwise. It resets to 0x01.
- R6: The enable mask is written at address 0x010 from data bits [7:0] and resets to 0x01. Writes to it while `wd_running` is 1 are ignored.
- R7: At the edge that raises the grant, all marks clear, so `pend_status` equals the mask again.
- R8: A `wd_start` pulse clears all marks. When it falls in the same cycle as a completing key write, the start wins: no grant is produced and the marks stay clear.
- R9: With an all-zero mask, no grant is ever produced.
- R10: `wr_ready` is always 1, and a write transfers in every cycle where `wr_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write transfer valid |
| wr_ready | output | 1 | Write transfer ready, always 1 |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data |
| wd_running | input | 1 | Watchdog is counting |
| wd_start | input | 1 | One-cycle pulse when the watchdog starts |
| en_mask | output | 8 | Slot enable mask |
| pend_status | output | 8 | Enabled slots still waiting for a key |
| reload_grant | output | 1 | One-cycle reload pulse to the counter |

## Verification
A start pulse and the key write that completes the enabled set can fall in the same cycle. The bench provokes this by driving `wd_start` high together with the last missing key. It then checks that no grant appears in the next cycle and that the pending status has returned to the full mask. A behavioural model compares the grant, the mask and the status on every clock, so the same collision is also judged cycle by cycle.

// File: rtl/rld_pkg.sv
package rld_pkg;
  parameter int unsigned RLD_NSLOT     = 8;
  parameter int unsigned RLD_ADDR_W    = 12;
  parameter int unsigned RLD_DATA_W    = 32;
  parameter logic [31:0] RLD_KEY       = 32'h6E52_4635;
  parameter logic [11:0] RLD_SLOT_BASE = 12'h600;
  parameter logic [11:0] RLD_MASK_ADDR = 12'h010;
endpackage

// File: rtl/rld_addr_dec.sv
module rld_addr_dec #(
  parameter int unsigned NSLOT     = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 12'h600,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 12'h010,
  parameter logic [DATA_W-1:0] KEY       = 32'h6E52_4635
) (
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NSLOT-1:0]  key_hit,
  output logic              mask_wr,
  output logic [NSLOT-1:0]  mask_data
);
  localparam int unsigned STRIDE = 4;
  logic key_ok;

  assign key_ok    = (wr_data == KEY);
  assign mask_wr   = wr_fire && (wr_addr == MASK_ADDR);
  assign mask_data = wr_data[NSLOT-1:0];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = SLOT_BASE + ADDR_W'(STRIDE * i);
    assign key_hit[i] = wr_fire && key_ok && (wr_addr == SLOT_ADDR);
  end
endmodule

// File: rtl/rld_grant_ctl.sv
module rld_grant_ctl #(
  parameter int unsigned NSLOT = 8
) (
  input  logic             run,
  input  logic             start,
  input  logic [NSLOT-1:0] en_mask,
  input  logic [NSLOT-1:0] req,
  input  logic [NSLOT-1:0] key_hit,
  output logic             fire
);
  logic [NSLOT-1:0] req_next;
  logic             mask_any;

  assign req_next = req | (key_hit & en_mask);
  assign mask_any = |en_mask;
  assign fire     = run && !start && mask_any && ((req_next & en_mask) == en_mask);
endmodule

// File: rtl/rld_req_bank.sv
module rld_req_bank #(
  parameter int unsigned NSLOT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic             fire,
  input  logic [NSLOT-1:0] en_mask,
  input  logic [NSLOT-1:0] key_hit,
  output logic [NSLOT-1:0] req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req <= '0;
    end else if (start || fire) begin
      req <= '0;
    end else if (run) begin
      req <= req | (key_hit & en_mask);
    end
  end

  // R8: a start pulse leaves no mark behind
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (req == '0));

  // R3: marks never rise while the watchdog is idle
  assert_idle_no_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> ((req & ~$past(req)) == '0));
endmodule

// File: rtl/reload_arbiter.sv
module reload_arbiter
  import rld_pkg::*;
#(
  parameter int unsigned NSLOT  = RLD_NSLOT,
  parameter int unsigned ADDR_W = RLD_ADDR_W,
  parameter int unsigned DATA_W = RLD_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wd_running,
  input  logic              wd_start,
  output logic [NSLOT-1:0]  en_mask,
  output logic [NSLOT-1:0]  pend_status,
  output logic              reload_grant
);
  localparam logic [NSLOT-1:0] MASK_RST = NSLOT'(1);

  logic             wr_fire;
  logic [NSLOT-1:0] key_hit;
  logic             mask_wr;
  logic [NSLOT-1:0] mask_data;
  logic [NSLOT-1:0] req;
  logic             fire;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  rld_addr_dec #(
    .NSLOT(NSLOT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SLOT_BASE(ADDR_W'(RLD_SLOT_BASE)), .MASK_ADDR(ADDR_W'(RLD_MASK_ADDR)),
    .KEY(DATA_W'(RLD_KEY))
  ) u_dec (
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
    .key_hit(key_hit), .mask_wr(mask_wr), .mask_data(mask_data)
  );

  rld_grant_ctl #(.NSLOT(NSLOT)) u_ctl (
    .run(wd_running), .start(wd_start), .en_mask(en_mask),
    .req(req), .key_hit(key_hit), .fire(fire)
  );

  rld_req_bank #(.NSLOT(NSLOT)) u_bank (
    .clk(clk), .rst_n(rst_n), .run(wd_running), .start(wd_start),
    .fire(fire), .en_mask(en_mask), .key_hit(key_hit), .req(req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_mask <= MASK_RST;
    end else if (mask_wr && !wd_running) begin
      en_mask <= mask_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reload_grant <= 1'b0;
    else        reload_grant <= fire;
  end

  assign pend_status = en_mask & ~req;

  // R6: mask is frozen across a running cycle
  assert_mask_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wd_running) |-> $stable(en_mask));

  // R7: marks are already clear when the grant is visible
  assert_grant_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reload_grant |-> (req == '0));

  // R4: grant only follows a running cycle
  assert_grant_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reload_grant |-> $past(wd_running));

  // R9: an empty mask never yields a grant
  assert_no_empty_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reload_grant |-> ($past(en_mask) != '0));

  // R10: the write channel never stalls
  assert_always_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

// File: tb/reload_arbiter_test.sv
module reload_arbiter_test;
  localparam logic [31:0] KEY  = 32'h6E52_4635;
  localparam logic [11:0] MADR = 12'h010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wd_running = 1'b0;
  logic        wd_start = 1'b0;
  logic [7:0]  en_mask;
  logic [7:0]  pend_status;
  logic        reload_grant;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // behavioural reference state
  int unsigned m_mask  = 1;
  int unsigned m_req   = 0;
  bit          m_grant = 1'b0;

  always #2.5 clk = ~clk;

  reload_arbiter uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wd_running(wd_running),
    .wd_start(wd_start), .en_mask(en_mask), .pend_status(pend_status),
    .reload_grant(reload_grant)
  );

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int unsigned hits;
    int unsigned nreq;
    if (!rst_n) begin
      m_mask = 1; m_req = 0; m_grant = 0;
    end else begin
      hits = 0;
      for (int i = 0; i < 8; i++)
        if (wr_valid && wr_addr == 12'h600 + 12'(4*i) && wr_data == KEY && m_mask[i])
          hits |= (1 << i);
      nreq = m_req | hits;
      m_grant = 0;
      if (wd_start) m_req = 0;
      else if (wd_running) begin
        if (m_mask != 0 && (nreq & m_mask) == m_mask) begin
          m_grant = 1; m_req = 0;
        end else m_req = nreq;
      end
      if (wr_valid && !wd_running && wr_addr == MADR) m_mask = wr_data & 32'hFF;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4 grant model", 32'(reload_grant), 32'(m_grant));
      check("R6 mask model", 32'(en_mask), m_mask);
      check("R5 status model", 32'(pend_status), m_mask & ~m_req);
    end
  end

  task automatic step(input bit v, input logic [11:0] a, input logic [31:0] d, input bit s);
    wr_valid = v; wr_addr = a; wr_data = d; wd_start = s;
    @(negedge clk);
    wr_valid = 1'b0; wd_start = 1'b0;
  endtask

  function automatic logic [11:0] slot(input int i);
    return 12'h600 + 12'(4*i);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset status", 32'(pend_status), 32'h01);
    check("R6 reset mask", 32'(en_mask), 32'h01);
    check("R4 reset grant", 32'(reload_grant), 0);
    check("R10 ready", 32'(wr_ready), 1);

    step(1, MADR, 32'h0B, 0);
    check("R6 mask write idle", 32'(en_mask), 32'h0B);
    step(1, slot(0), KEY, 0);
    check("R3 key while idle", 32'(pend_status), 32'h0B);

    wd_running = 1'b1;
    step(1, slot(0), 32'h1234_5678, 0);
    check("R2 wrong value", 32'(pend_status), 32'h0B);
    step(1, slot(0), KEY, 0);
    check("R1 slot0 key", 32'(pend_status), 32'h0A);
    step(1, slot(0), 32'h6E52_4634, 0);
    check("R2 no clear", 32'(pend_status), 32'h0A);
    step(1, slot(2), KEY, 0);
    check("R3 disabled slot", 32'(pend_status), 32'h0A);
    step(1, MADR, 32'hFF, 0);
    check("R6 mask frozen", 32'(en_mask), 32'h0B);
    step(1, slot(1), KEY, 0);
    check("R1 slot1 key", 32'(pend_status), 32'h08);
    check("R4 no early grant", 32'(reload_grant), 0);
    step(1, slot(3), KEY, 0);
    check("R4 grant", 32'(reload_grant), 1);
    check("R7 marks cleared", 32'(pend_status), 32'h0B);
    step(0, '0, '0, 0);
    check("R4 one cycle", 32'(reload_grant), 0);

    // start collides with the completing key
    step(1, slot(0), KEY, 0);
    step(1, slot(1), KEY, 0);
    step(1, slot(3), KEY, 1);
    check("R8 start wins grant", 32'(reload_grant), 0);
    check("R8 start wins status", 32'(pend_status), 32'h0B);
    step(1, slot(0), KEY, 1);
    check("R8 start clears", 32'(pend_status), 32'h0B);

    // empty mask
    wd_running = 1'b0;
    step(1, MADR, 32'h00, 0);
    wd_running = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step(1, slot(i), KEY, 0);
      check("R9 empty mask", 32'(reload_grant), 0);
    end
    check("R9 status empty", 32'(pend_status), 0);

    // full mask, reverse order
    wd_running = 1'b0;
    step(1, MADR, 32'hFF, 0);
    wd_running = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      step(1, slot(i), KEY, 0);
      check("R4 full mask", 32'(reload_grant), (i == 0) ? 1 : 0);
    end
    check("R7 full cleared", 32'(pend_status), 32'hFF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule